// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block watches for a stalled program. A slow oscillator tick is divided by a selectable power of two and then counted in an 8-bit timeout counter. If software fails to feed the watchdog before the counter wraps, the block pulses a system-reset request. It also records that the watchdog, and not some other source, caused the reset.

Software reaches the block over a byte-wide register bus with two registers. The control register holds the reset-cause flag, the enable and the divider select. Writes to it take effect only while a separate access-protection unit asserts an unlock signal. The refresh register is write-only. Only one byte value written to it restarts the count.

An external strap can force the watchdog off, whatever the software enable says. The reset-cause flag is cleared only by software or by this block's own reset input. That input is wired to the external and power-on resets, so the flag survives the system reset that the watchdog itself requests.

Top module: `wdt_keyed`

## Requirements
- R1: After `rst_n` is released, the control register (address 0) reads 0x04 and `rst_req` is low.
- R2: A write to the control register changes it only while `unlock` is 1. With `unlock` at 0 the register keeps its value. The layout is bit 7 = reset-cause flag, bit 6 = enable, bits 5:4 = read as 0, bits 3:0 = divider select n.
- R3: While enabled, the watchdog counts `tick` cycles. `rst_req` goes high on the clock edge that completes 256·2^n counted ticks after the count was last cleared. Cycles with `tick` low do not count.
- R4: Writing 0x55 to the refresh register (address 1) clears the count, so a full 256·2^n ticks are needed from that write. Any other value written there leaves the count unchanged.
- R5: `rst_req` is a pulse that lasts a single clock cycle.
- R6: While `cfg_off` is 1, `rst_req` stays low whatever the enable bit says. While the watchdog is off (`cfg_off` = 1 or enable = 0), the count is held at zero.
- R7: A timeout sets control bit 7. An unlocked control write with bit 7 = 0 clears the flag; one with bit 7 = 1 leaves it as it is. `rst_n` clears it.
- R8: The refresh register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low external / power-on reset |
| tick | input | 1 | One-cycle enable from the slow oscillator |
| cfg_off | input | 1 | Strap: 1 forces the watchdog off |
| unlock | input | 1 | Write permission for the control register |
| addr | input | ADDR_W | Register address (0 control, 1 refresh) |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rdata | output | 8 | Read data for `addr` |
| rst_req | output | 1 | Single-cycle system-reset request |

## Verification
The hardest cases to reach are those where the count must be shown to have been cleared, frozen or left alone without any view of the counter. The stimulus turns these into timing measurements. It times the interval from a chosen write edge to the reset pulse, and it refreshes, pauses the tick or raises the strap part-way through a count. The measured distance to the next pulse then shows whether the count restarted, held or carried on.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int ADDR_W = 2,
  parameter int CNT_W = 8,
  parameter logic [7:0] FEED_KEY = 8'h55,
  parameter logic [3:0] SEL_RST = 4'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_off,
  input  logic              unlock,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  output logic [7:0]        rdata,
  output logic              rst_req
);
  localparam int PRE_W = 15;
  localparam logic [ADDR_W-1:0] A_CTL = '0;
  localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(1);

  logic             flag_q, en_q;
  logic [3:0]       sel_q;
  logic [PRE_W-1:0] pre_q, mask;
  logic [CNT_W-1:0] cnt_q;
  logic             active, ptick, wrap, ctl_wr, feed;

  assign active = en_q & ~cfg_off;
  assign mask   = ~({PRE_W{1'b1}} << sel_q);
  assign ptick  = active & tick & (pre_q >= mask);
  assign wrap   = ptick & (&cnt_q);
  assign ctl_wr = wr_en & unlock & (addr == A_CTL);
  assign feed   = wr_en & (addr == A_KEY) & (wdata == FEED_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= SEL_RST;
    end else if (ctl_wr) begin
      en_q  <= wdata[6];
      sel_q <= wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  flag_q <= 1'b0;
    else if (wrap)               flag_q <= 1'b1;
    else if (ctl_wr && !wdata[7]) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!active || feed) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      if (ptick) begin
        pre_q <= '0;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= wrap;
  end

  assign rdata = (addr == A_CTL) ? {flag_q, en_q, 2'b00, sel_q} : 8'h00;
endmodule

module wdt_keyed_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_off,
  input logic              unlock,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              rst_req,
  input logic              flag,
  input logic              en,
  input logic [3:0]        sel
);
  a_r2_locked_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlock && addr == '0) |=> ($stable(en) && $stable(sel)));
  a_r4_feed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(1) && wdata == 8'h55) |=> !rst_req);
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r6_strap_off: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_off |=> !rst_req);
  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> flag);
endmodule

bind wdt_keyed wdt_keyed_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_off(cfg_off), .unlock(unlock),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .rst_req(rst_req),
  .flag(flag_q), .en(en_q), .sel(sel_q)
);

// File: tb/wdt_keyed_bench.sv
module wdt_keyed_bench;
  logic clk = 0, rst_n = 0, tick = 1, cfg_off = 0, unlock = 1, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic rst_req;
  int total = 0, bad = 0, cyc = 0;

  wdt_keyed u_wdt_keyed (.clk(clk), .rst_n(rst_n), .tick(tick), .cfg_off(cfg_off),
    .unlock(unlock), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rdata(rdata),
    .rst_req(rst_req));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [3:0] VSEL [4] = '{4'd0, 4'd1, 4'd3, 4'd5};
  localparam int         VEXP [4] = '{256, 512, 2048, 8192};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic start(input logic [3:0] s);
    wr(0, 8'h00);
    wr(0, {4'b0100, s});
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (rst_req) break;
    end
  endtask

  task automatic run(input int k, output int seen);
    seen = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (rst_req) seen = 1;
    end
  endtask

  initial begin
    logic [7:0] d;
    int n, s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, d); check("R1 ctl reset", d, 8'h04);
    check("R1 req low", rst_req, 0);
    rd(1, d); check("R8 key reads zero", d, 8'h00);

    for (int v = 0; v < 4; v++) begin
      start(VSEL[v]); measure(n);
      check($sformatf("R3 period sel=%0d", VSEL[v]), n, VEXP[v]);
    end
    @(negedge clk); check("R5 pulse one cycle", rst_req, 0);

    start(4'd4); measure(n); check("R3 default sel", n, 4096);

    start(0); run(200, s); wr(1, 8'h55); measure(n);
    check("R4 feed restarts", n, 256);
    start(0); run(200, s); wr(1, 8'h54); measure(n);
    check("R4 wrong key ignored", n, 55);

    start(0); run(100, s);
    @(negedge clk); tick = 0; run(49, s);
    @(negedge clk); tick = 1; measure(n);
    check("R3 idle ticks not counted", n, 156);

    cfg_off = 1; start(0); run(400, s);
    check("R6 strap blocks req", s, 0);
    @(negedge clk); cfg_off = 0; measure(n);
    check("R6 count held clear", n, 256);

    unlock = 0; wr(0, 8'h0F); unlock = 1;
    rd(0, d); check("R2 locked write ignored", d & 8'h7F, 8'h40);
    wr(0, 8'h4F); rd(0, d); check("R2 unlocked write", d & 8'h7F, 8'h4F);

    start(0); measure(n);
    rd(0, d); check("R7 flag set", d[7], 1);
    wr(0, 8'hC0); rd(0, d); check("R7 write one keeps", d[7], 1);
    wr(0, 8'h40); rd(0, d); check("R7 write zero clears", d[7], 0);
    start(0); measure(n);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(0, d); check("R7 reset clears flag", d, 8'h04);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule